// File: doc/BRIEF.md
# Scalar Morton Interleave Unit

This unit is a one-stage execution pipe that merges coordinate operands into a single Morton-ordered (Z-order) word. Such words are used as hash keys or as cache-friendly indices for 2D and 3D data. An opcode picks one of two merges.

The pair merge places the bits of two operands side by side, alternating between them. The triple merge takes an operand that already holds a two-way merge and inserts one bit of a second operand after every pair of its bits.

Neither merge has more than two operands per pass, so larger orders are built in more than one pass:
- A 3D code comes from a pair merge of X and Y, followed by a triple merge of that result with Z.
- A 4D code comes from three pair merges.

The data path has one valid strobe in each direction and no ready. The unit accepts an operation on every cycle and never applies back-pressure. The consumer must take each result in the cycle its valid strobe is high, because the next accepted operation overwrites it. When no operation is accepted, the result register holds its value.

Top module: `morton_interleave_unit`

## Requirements
- R1: With opcode 2'b00 (pair merge), result bit 2i equals bit i of `src_a_i` and result bit 2i+1 equals bit i of `src_b_i`, for i = 0..31.
- R2: With opcode 2'b01 (triple merge), result bits 3i and 3i+1 equal bits 2i and 2i+1 of `src_a_i`, and result bit 3i+2 equals bit i of `src_b_i`, for every position below 64 whose source bit exists.
- R3: In triple merge, bits 21..31 of `src_b_i` have no effect, and result bits 48..63, apart from those carrying `src_b_i` bits 16..20 (positions 50, 53, 56, 59, 62), are zero.
- R4: `res_vld_o` equals `op_vld_i` delayed by one clock.
- R5: The result register changes only after a cycle with `op_vld_i` high. Otherwise it holds its value, whatever the opcode and operands are.
- R6: A synchronous active-high `rst_i` clears `res_vld_o` and `res_o` to zero.
- R7: Opcodes 2'b10 and 2'b11 produce an all-zero result, and `res_vld_o` still follows `op_vld_i`.
- R8: A pair merge of X and Y (16 bits each), with its low 32 bits then triple-merged with Z, gives a code in which bit 3i is X[i], bit 3i+1 is Y[i] and bit 3i+2 is Z[i].
- R9: Pair-merging W with Y and X with Z (8 bits each), then pair-merging those two results, gives a code in which bits 4i..4i+3 are W[i], X[i], Y[i] and Z[i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_vld_i | input | 1 | An operation is presented this cycle |
| op_mode_i | input | 2 | Opcode: 00 pair merge, 01 triple merge, others give zero |
| src_a_i | input | 32 | First operand (or the pre-merged operand in triple mode) |
| src_b_i | input | 32 | Second operand (or the third coordinate in triple mode) |
| res_vld_o | output | 1 | Result valid, one cycle after `op_vld_i` |
| res_o | output | 64 | Merged result |

## Verification
The hardest case to reach is the top of the result in triple mode. There, the first operand has run out of bits while the second still supplies a few before the 64-bit limit. A correct design must place those few bits and drop the rest. The stimulus therefore includes triple-mode vectors with all ones and with a lone high bit in `src_b_i` at positions 20 and 21, which expose a wrong cut-off on either side. The multi-pass 3D and 4D codes are built by feeding captured results back in as operands, as a user would.

// File: rtl/mil_pkg.sv
package mil_pkg;
  localparam int unsigned MIL_OPW  = 32;
  localparam int unsigned MIL_RESW = 64;
  localparam int unsigned MIL_MODEW = 2;

  localparam logic [MIL_MODEW-1:0] MIL_PAIR   = 2'b00;
  localparam logic [MIL_MODEW-1:0] MIL_TRIPLE = 2'b01;
endpackage

// File: rtl/mil_pair_merge.sv
module mil_pair_merge #(
  parameter int unsigned OPW  = 32,
  parameter int unsigned RESW = 64
) (
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  output logic [RESW-1:0] y_o
);
  for (genvar p = 0; p < RESW; p++) begin : g_bit
    localparam int unsigned SRC = p / 2;
    if ((p % 2 == 0) && (SRC < OPW)) begin : g_a
      assign y_o[p] = a_i[SRC];
    end else if ((p % 2 == 1) && (SRC < OPW)) begin : g_b
      assign y_o[p] = b_i[SRC];
    end else begin : g_zero
      assign y_o[p] = 1'b0;
    end
  end

  logic unused_ops;
  assign unused_ops = ^{a_i, b_i};
endmodule

// File: rtl/mil_triple_merge.sv
module mil_triple_merge #(
  parameter int unsigned OPW  = 32,
  parameter int unsigned RESW = 64
) (
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  output logic [RESW-1:0] y_o
);
  for (genvar p = 0; p < RESW; p++) begin : g_bit
    localparam int unsigned GRP  = p / 3;
    localparam int unsigned SLOT = p % 3;
    localparam int unsigned AIDX = 2 * GRP + SLOT;
    if ((SLOT == 2) && (GRP < OPW)) begin : g_b
      assign y_o[p] = b_i[GRP];
    end else if ((SLOT != 2) && (AIDX < OPW)) begin : g_a
      assign y_o[p] = a_i[AIDX];
    end else begin : g_zero
      assign y_o[p] = 1'b0;
    end
  end

  logic unused_ops;
  assign unused_ops = ^{a_i, b_i};
endmodule

// File: rtl/morton_interleave_unit.sv
module morton_interleave_unit
  import mil_pkg::*;
#(
  parameter int unsigned OPW  = MIL_OPW,
  parameter int unsigned RESW = MIL_RESW
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            op_vld_i,
  input  logic [1:0]      op_mode_i,
  input  logic [OPW-1:0]  src_a_i,
  input  logic [OPW-1:0]  src_b_i,
  output logic            res_vld_o,
  output logic [RESW-1:0] res_o
);
  localparam int unsigned TOP_B_POS = ((RESW - 1) / 3) * 3;

  logic [RESW-1:0] pair_y, triple_y, next_y;

  mil_pair_merge #(.OPW(OPW), .RESW(RESW)) u_pair (
    .a_i(src_a_i), .b_i(src_b_i), .y_o(pair_y)
  );

  mil_triple_merge #(.OPW(OPW), .RESW(RESW)) u_triple (
    .a_i(src_a_i), .b_i(src_b_i), .y_o(triple_y)
  );

  always_comb begin
    unique case (op_mode_i)
      MIL_PAIR:   next_y = pair_y;
      MIL_TRIPLE: next_y = triple_y;
      default:    next_y = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_vld_o <= 1'b0;
      res_o     <= '0;
    end else begin
      res_vld_o <= op_vld_i;
      if (op_vld_i) res_o <= next_y;
    end
  end

  // R4: output strobe tracks input strobe by one clock
  a_r4_vld_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    op_vld_i |=> res_vld_o);
  a_r4_vld_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !op_vld_i |=> !res_vld_o);
  // R5: no accepted operation, no change
  a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !op_vld_i |=> $stable(res_o));
  // R7: unused opcodes yield zero
  a_r7_unused_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_vld_i && op_mode_i[1]) |=> (res_o == '0));
  // R3: the slot past the last operand bit in triple mode stays empty
  a_r3_top_slot: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_vld_i && op_mode_i == MIL_TRIPLE && (2 * (TOP_B_POS / 3) >= OPW))
    |=> (res_o[TOP_B_POS] == 1'b0));
endmodule

// File: tb/morton_interleave_unit_tb.sv
module morton_interleave_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_i;
  logic        op_vld_i;
  logic [1:0]  op_mode_i;
  logic [31:0] src_a_i, src_b_i;
  logic        res_vld_o;
  logic [63:0] res_o;

  int applied = 0;
  int miss = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  morton_interleave_unit dut_i (
    .clk_i(clk), .rst_i(rst_i), .op_vld_i(op_vld_i), .op_mode_i(op_mode_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .res_vld_o(res_vld_o), .res_o(res_o)
  );

  // {mode, a, b}
  localparam logic [65:0] VEC [12] = '{
    {2'b00, 32'h0000_0001, 32'h0000_0000},
    {2'b00, 32'h0000_0000, 32'h8000_0000},
    {2'b00, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'b00, 32'h1234_5678, 32'h9ABC_DEF0},
    {2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b01, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'b01, 32'h0000_0000, 32'hFFFF_FFFF},
    {2'b01, 32'h0000_0000, 32'h0010_0000},
    {2'b01, 32'h0000_0000, 32'h0020_0000},
    {2'b01, 32'hA5A5_C3C3, 32'h0F0F_1234},
    {2'b01, 32'h8000_0001, 32'h0000_8001},
    {2'b00, 32'hDEAD_BEEF, 32'h0BAD_F00D}
  };

  function automatic logic [63:0] model(input logic [1:0] m,
                                        input logic [31:0] a,
                                        input logic [31:0] b);
    logic [63:0] r = '0;
    for (int p = 0; p < 64; p++) begin
      if (m == 2'b00) begin
        r[p] = (p % 2 == 0) ? a[p/2] : b[p/2];
      end else if (m == 2'b01) begin
        int g = p / 3;
        int s = p % 3;
        if (s == 2) r[p] = (g < 32) ? b[g] : 1'b0;
        else if (2*g + s < 32) r[p] = a[2*g + s];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_vld_i = 1'b1; op_mode_i = m; src_a_i = a; src_b_i = b;
    @(negedge clk);
    op_vld_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
      $finish;
    end
  end

  initial begin
    logic [63:0] held, t1, t2, e;
    logic [15:0] x16, y16, z16;
    logic [7:0]  w8, x8, y8, z8;
    rst_i = 1'b1; op_vld_i = 1'b0; op_mode_i = 2'b00;
    src_a_i = 32'hFFFF_FFFF; src_b_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R6 reset state
    check("R6 vld", {63'd0, res_vld_o}, 64'd0);
    check("R6 res", res_o, 64'd0);
    rst_i = 1'b0;

    // R1 R2 R3 R4: vector table
    for (int k = 0; k < 12; k++) begin
      issue(VEC[k][65:64], VEC[k][63:32], VEC[k][31:0]);
      check(VEC[k][65:64] == 2'b00 ? "R1 pair" : "R2/R3 triple",
            res_o, model(VEC[k][65:64], VEC[k][63:32], VEC[k][31:0]));
      check("R4 vld high", {63'd0, res_vld_o}, 64'd1);
    end
    // R3 explicit: b bit 21 drops out entirely
    issue(2'b01, 32'h0, 32'hFFE0_0000);
    check("R3 b hi ignored", res_o, 64'd0);

    // R5 hold and R4 idle
    held = res_o;
    @(negedge clk);
    op_vld_i = 1'b0; op_mode_i = 2'b00; src_a_i = 32'h5555_AAAA; src_b_i = 32'h1357_9BDF;
    @(negedge clk);
    check("R4 vld low", {63'd0, res_vld_o}, 64'd0);
    check("R5 hold", res_o, held);

    // R7 unused opcodes
    issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R7 mode10 zero", res_o, 64'd0);
    check("R7 vld", {63'd0, res_vld_o}, 64'd1);
    issue(2'b00, 32'h1, 32'h1);
    issue(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R7 mode11 zero", res_o, 64'd0);

    // R8 3D in two passes
    x16 = 16'hC3A5; y16 = 16'h1E0F; z16 = 16'hF00D;
    issue(2'b00, {16'd0, x16}, {16'd0, y16});
    t1 = res_o;
    issue(2'b01, t1[31:0], {16'd0, z16});
    e = '0;
    for (int i = 0; i < 16; i++) begin
      e[3*i] = x16[i]; e[3*i+1] = y16[i]; e[3*i+2] = z16[i];
    end
    check("R8 3D code", res_o, e);

    // R9 4D in three pair passes
    w8 = 8'h96; x8 = 8'h3C; y8 = 8'hE1; z8 = 8'h5A;
    issue(2'b00, {24'd0, w8}, {24'd0, y8});
    t1 = res_o;
    issue(2'b00, {24'd0, x8}, {24'd0, z8});
    t2 = res_o;
    issue(2'b00, t1[31:0], t2[31:0]);
    e = '0;
    for (int i = 0; i < 8; i++) begin
      e[4*i] = w8[i]; e[4*i+1] = x8[i]; e[4*i+2] = y8[i]; e[4*i+3] = z8[i];
    end
    check("R9 4D code", res_o, e);

    // R6 reset mid-stream
    @(negedge clk);
    rst_i = 1'b1;
    @(negedge clk);
    rst_i = 1'b0;
    check("R6 res after reset", res_o, 64'd0);
    check("R6 vld after reset", {63'd0, res_vld_o}, 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
    $finish;
  end
endmodule